// File: doc/BRIEF.md
# Modem Transmit Bit Source Selector

This block picks the serial bit handed to the modulator on every baud-bit strobe. A two-bit pattern field chooses between the user transmit-data input and three built-in test patterns: alternating mark/space, steady mark and steady space. The chosen bit then either runs through a self-synchronizing scrambler with polynomial 1 + x^-14 + x^-17, or goes around it when the bypass control is set. Bypass behaves the same way in both the phase-shift and QAM transmit modes. The control fields are plain input ports, and they are sampled on the strobe.

The alternating generator is a two-state machine with states `ALT_MARK` and `ALT_SPACE`. Reset enters `ALT_MARK`. Each strobe takes `ALT_MARK -> ALT_SPACE` or `ALT_SPACE -> ALT_MARK`, and the machine stays in its state when there is no strobe. It runs on every strobe whatever the pattern field holds. The scrambler shift register advances only on strobes where the scrambler is engaged. The output is registered and changes only on a strobe.

Top module: `tx_bit_source`

## Requirements
- R1: While reset is asserted and after it is released, the output is mark (1), the scrambler register is all zero and the alternating generator is in `ALT_MARK`.
- R2: Pattern field 2'b00 takes the source bit from `tx_data`.
- R3: Pattern field 2'b01 takes the source bit from the alternating generator. The generator gives 1 on the first strobe after reset and toggles on every strobe in every pattern mode.
- R4: Pattern field 2'b10 gives a source bit of 1 and 2'b11 gives 0. In both cases `tx_data` has no effect.
- R5: With `scr_bypass`=0, the output bit is the source bit XOR register stage 14 XOR register stage 17. Stage 1 is the most recent bit. The output bit is then shifted into stage 1.
- R6: With `scr_bypass`=1, the output bit equals the source bit and the scrambler register holds its contents. Scrambling resumes from the held state when bypass is cleared.
- R7: On a cycle with `bit_en`=0, the output, the scrambler register and the alternating generator all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Baud-bit strobe |
| pat_sel | input | 2 | Source select: 00 user, 01 alternating, 10 mark, 11 space |
| scr_bypass | input | 1 | 1 routes the source bit around the scrambler |
| tx_data | input | 1 | User transmit data bit |
| tx_bit_out | output | 1 | Registered bit toward the modulator |

## Verification
Two things can land on the same strobe: the alternating generator stepping, and the scrambler either advancing or freezing because of the bypass control. The bench provokes this by sending the alternating pattern while flipping `scr_bypass` on every strobe, and by changing the pattern field in the middle of a scrambled run. Each result is compared with a reference model in the bench that applies R3, R5 and R6 separately. A wrong freeze, a missed toggle or a tap taken from the wrong stage shows up as a mismatch in the scrambled bit stream that follows.

// File: rtl/tx_src_pkg.sv
package tx_src_pkg;

    typedef enum logic [1:0] {
        PAT_USER  = 2'b00,
        PAT_ALT   = 2'b01,
        PAT_MARK  = 2'b10,
        PAT_SPACE = 2'b11
    } pat_sel_e;

    typedef enum logic {
        ALT_SPACE = 1'b0,
        ALT_MARK  = 1'b1
    } alt_state_e;

    localparam logic MARK_BIT  = 1'b1;
    localparam logic SPACE_BIT = 1'b0;

endpackage

// File: rtl/tx_alt_gen.sv
module tx_alt_gen
    import tx_src_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    output logic alt_bit
);

    alt_state_e state_q;
    alt_state_e state_d;

    // Next-state logic: toggle on every strobe.
    always_comb begin
        state_d = state_q;
        if (bit_en) begin
            unique case (state_q)
                ALT_MARK:  state_d = ALT_SPACE;
                ALT_SPACE: state_d = ALT_MARK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ALT_MARK;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ALT_MARK:  alt_bit = MARK_BIT;
            ALT_SPACE: alt_bit = SPACE_BIT;
        endcase
    end

    a_r3_toggle_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> (alt_bit != $past(alt_bit)));

    a_r7_alt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(alt_bit));

endmodule

// File: rtl/tx_pat_mux.sv
module tx_pat_mux
    import tx_src_pkg::*;
(
    input  logic [1:0] pat_sel,
    input  logic       tx_data,
    input  logic       alt_bit,
    output logic       src_bit
);

    pat_sel_e sel;
    assign sel = pat_sel_e'(pat_sel);

    always_comb begin
        unique case (sel)
            PAT_USER:  src_bit = tx_data;
            PAT_ALT:   src_bit = alt_bit;
            PAT_MARK:  src_bit = MARK_BIT;
            PAT_SPACE: src_bit = SPACE_BIT;
        endcase
    end

endmodule

// File: rtl/tx_scrambler.sv
module tx_scrambler #(
    parameter int LEN   = 17,
    parameter int TAP_A = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bypass,
    input  logic src_bit,
    output logic scr_bit
);

    localparam int IDX_A = TAP_A - 1;
    localparam int IDX_B = LEN - 1;

    logic [LEN-1:0] sr_q;
    logic           mixed;

    assign mixed   = src_bit ^ sr_q[IDX_A] ^ sr_q[IDX_B];
    assign scr_bit = bypass ? src_bit : mixed;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (bit_en && !bypass)
            sr_q <= {sr_q[LEN-2:0], mixed};
    end

    a_r6_reg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bypass) |=> $stable(sr_q));

    a_r7_reg_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(sr_q));

    a_r5_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !bypass) |=> (sr_q[LEN-1:1] == $past(sr_q[LEN-2:0])));

    initial begin
        a_tap_order: assert (TAP_A > 0 && TAP_A < LEN);
    end

endmodule

// File: rtl/tx_bit_source.sv
module tx_bit_source #(
    parameter int SCR_LEN = 17,
    parameter int SCR_TAP = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic [1:0] pat_sel,
    input  logic       scr_bypass,
    input  logic       tx_data,
    output logic       tx_bit_out
);
    import tx_src_pkg::*;

    logic alt_bit;
    logic src_bit;
    logic scr_bit;

    tx_alt_gen u_alt (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .alt_bit (alt_bit)
    );

    tx_pat_mux u_mux (
        .pat_sel (pat_sel),
        .tx_data (tx_data),
        .alt_bit (alt_bit),
        .src_bit (src_bit)
    );

    tx_scrambler #(
        .LEN   (SCR_LEN),
        .TAP_A (SCR_TAP)
    ) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bypass  (scr_bypass),
        .src_bit (src_bit),
        .scr_bit (scr_bit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      tx_bit_out <= MARK_BIT;
        else if (bit_en) tx_bit_out <= scr_bit;
    end

    a_r6_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && scr_bypass) |=> (tx_bit_out == $past(src_bit)));

    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit_out));

    a_r4_mark_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && scr_bypass && pat_sel == 2'b10) |=> tx_bit_out);

    a_r4_space_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && scr_bypass && pat_sel == 2'b11) |=> !tx_bit_out);

endmodule

// File: tb/tx_bit_source_tb.sv
module tx_bit_source_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [1:0] pat_sel = 2'b00;
    logic       scr_bypass = 1'b1;
    logic       tx_data = 1'b0;
    logic       tx_bit_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t q[$];

    // Reference model state
    logic [16:0] m_sr = '0;
    logic        m_alt = 1'b1;
    logic        m_out = 1'b1;

    always #10 clk = ~clk;

    tx_bit_source u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .pat_sel    (pat_sel),
        .scr_bypass (scr_bypass),
        .tx_data    (tx_data),
        .tx_bit_out (tx_bit_out)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Driver: one cycle, expected result pushed after the edge.
    task automatic drive(input logic [1:0] p, input logic byp, input logic d,
                         input logic en, input string req);
        logic src;
        @(negedge clk);
        pat_sel = p; scr_bypass = byp; tx_data = d; bit_en = en;
        @(posedge clk);
        if (en) begin
            case (p)
                2'b00:   src = d;
                2'b01:   src = m_alt;
                2'b10:   src = 1'b1;
                default: src = 1'b0;
            endcase
            if (byp) m_out = src;
            else begin
                m_out = src ^ m_sr[13] ^ m_sr[16];
                m_sr  = {m_sr[15:0], m_out};
            end
            m_alt = ~m_alt;
        end
        q.push_back('{m_out, req});
    endtask

    // Monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(tx_bit_out, it.exp, it.req);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tx_bit_out, 1'b1, "R1 reset output mark");
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_bit_out, 1'b1, "R1 after release");

        // R3: first strobe after reset is mark
        drive(2'b01, 1'b1, 1'b0, 1'b1, "R3 alt first");
        for (int i = 0; i < 5; i++) drive(2'b01, 1'b1, 1'b0, 1'b1, "R3 alt toggle");

        // R2: user data, bypassed
        drive(2'b00, 1'b1, 1'b1, 1'b1, "R2 user 1");
        drive(2'b00, 1'b1, 1'b0, 1'b1, "R2 user 0");
        drive(2'b00, 1'b1, 1'b1, 1'b1, "R2 user 1b");

        // R4: constants ignore tx_data
        drive(2'b10, 1'b1, 1'b0, 1'b1, "R4 mark");
        drive(2'b10, 1'b1, 1'b0, 1'b1, "R4 mark again");
        drive(2'b11, 1'b1, 1'b1, 1'b1, "R4 space");
        drive(2'b11, 1'b1, 1'b1, 1'b1, "R4 space again");

        // R7: idle cycles hold everything
        for (int i = 0; i < 4; i++) drive(2'b11 - 2'(i), 1'b0, 1'b1, 1'b0, "R7 idle hold");
        drive(2'b01, 1'b1, 1'b0, 1'b1, "R7 alt resumes");

        // R5: scrambled user data (register still zero after bypass)
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(2'b00, 1'b0, lfsr[0], 1'b1, "R5 scramble user");
        end
        // R5: scrambled space and mark
        for (int i = 0; i < 20; i++) drive(2'b11, 1'b0, 1'b1, 1'b1, "R5 scramble space");
        for (int i = 0; i < 10; i++) drive(2'b10, 1'b0, 1'b0, 1'b1, "R5 scramble mark");

        // R6: bypass freezes register; resume continues from held state
        for (int i = 0; i < 6; i++) drive(2'b00, 1'b1, 1'(i), 1'b1, "R6 bypass pass");
        for (int i = 0; i < 20; i++) drive(2'b11, 1'b0, 1'b0, 1'b1, "R6 resume scramble");

        // Concurrency: alternating with bypass flipping each strobe, idle gaps
        for (int i = 0; i < 40; i++) begin
            drive(2'b01, 1'(i % 2), 1'b0, 1'b1, "R3 R6 alt with bypass flip");
            if (i % 7 == 3) drive(2'b10, 1'b0, 1'b1, 1'b0, "R7 idle mid run");
        end
        // Pattern change mid scrambled run
        for (int i = 0; i < 24; i++)
            drive(2'(i % 4), 1'b0, 1'(i / 3), 1'b1, "R2 R4 R5 pattern switch");

        // Reset mid run returns to mark, alt at mark, register zero
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        while (q.size() > 0) @(negedge clk);
        check(tx_bit_out, 1'b1, "R1 reset mid run");
        rst_n = 1'b1;
        m_sr = '0; m_alt = 1'b1; m_out = 1'b1;
        drive(2'b01, 1'b0, 1'b0, 1'b1, "R1 R3 alt mark after reset");
        for (int i = 0; i < 20; i++) drive(2'b11, 1'b0, 1'b0, 1'b1, "R1 zero register after reset");

        @(negedge clk);
        bit_en = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule